// File: doc/BRIEF.md
# Serviced Watchdog Timer with Prescaler

This block guards a processor subsystem against software that stops making progress. A 16-bit down-counter is loaded with a programmable time-out value. It decrements on every system clock, or once per prescaler period when the slow range is selected. If software does not service it in time, the counter reaches zero. The block then raises a one-cycle request on one of two outputs: a hard-reset request to the reset controller or a machine-check interrupt request to the interrupt controller. A control bit picks which output is used.

Software reaches the block through a simple synchronous port. The port has a write strobe with an address and data, and a combinational read path with its own address. Software may program the control word only once after reset. It keeps the timer alive by writing a two-word key sequence to the service register. It can watch the remaining time through the count register. A new time-out value does not take effect until the next complete service sequence.

Top module: `wdog_timer`

## Requirements
- R1: While reset is asserted and right after it, the control word reads 0x0005FFFF and the count reads 0x0000FFFF. Both request outputs are low. The control word fields are: time-out in bits [15:0], enable in bit 16, prescale select in bit 17, and route in bit 18.
- R2: Address 0 is the control word (read/write). Address 1 is the service register (write-only, reads 0). Address 2 is the count register (read-only), with the counter in bits [15:0] and zeros above.
- R3: With enable=1 and prescale select=0, the count decreases by one on every clock edge.
- R4: With prescale select=1, the count decreases once every 2^PRESC_LOG2 clocks (65,536 by default). A service reload restarts the prescaler from zero, so the first decrement comes exactly 2^PRESC_LOG2 clocks after the reload.
- R5: On the clock edge where the count goes from 1 to 0, the selected request output goes high for exactly one cycle. After that the count stays at 0 until a reload.
- R6: Route=1 sends the expiry to hard_rst_req_o, and route=0 sends it to mchk_req_o. The two outputs are never high together.
- R7: Writing a new time-out value leaves the running count unchanged. The count takes the new value only on the edge that completes a service sequence.
- R8: A service sequence is a write of 0x0000556C to address 1 followed by a write of 0x0000AA39 to address 1. Any other value written to address 1 in between cancels the sequence. A write of 0x0000AA39 that does not follow 0x0000556C reloads nothing.
- R9: With enable=0, the count and the prescaler hold their values. No request is raised.
- R10: Only the first control-word write after reset takes effect. Every later control-word write is ignored, including any attempt to set enable again.
- R11: A service reload with a time-out of 0 leaves the count at 0 and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_waddr_i | input | 2 | Write register address |
| bus_wdata_i | input | 32 | Write data |
| bus_raddr_i | input | 2 | Read register address |
| bus_rdata_o | output | 32 | Read data, combinational from bus_raddr_i |
| hard_rst_req_o | output | 1 | One-cycle hard-reset request on expiry |
| mchk_req_o | output | 1 | One-cycle machine-check interrupt request on expiry |

## Verification
The count register exposes the decrementer directly. A wrong reload, a missed or extra decrement, or a counter that runs while disabled therefore shows up in the very next read. Prescaler faults are visible only at the first decrement after a reload, so the bench samples the count one cycle before and one cycle after that edge. A stuck or mis-cancelled key sequence appears as a count that did or did not jump back to the time-out value on the second key write. A wrong route or a pulse longer than one cycle appears on the request outputs in the cycle the count reaches zero and in the cycle after.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned CTRL_W = CNT_W + 3;
  localparam int unsigned BUS_W  = 32;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SVC  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  localparam logic [BUS_W-1:0] KEY_ARM  = 32'h0000_556C;
  localparam logic [BUS_W-1:0] KEY_FIRE = 32'h0000_AA39;

  typedef struct packed {
    logic             route;  // 1: hard reset, 0: machine check
    logic             presc;
    logic             en;
    logic [CNT_W-1:0] tmo;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{route: 1'b1, presc: 1'b0, en: 1'b1, tmo: '1};
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       waddr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output ctrl_t            ctrl_o,
  output logic             reload_o
);
  ctrl_t ctrl_q;
  logic  locked_q;
  logic  armed_q;
  logic  ctrl_wr, svc_wr;
  logic  unused_hi;

  assign ctrl_wr   = we_i && (waddr_i == ADDR_CTRL);
  assign svc_wr    = we_i && (waddr_i == ADDR_SVC);
  assign unused_hi = ^wdata_i[BUS_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      locked_q <= 1'b0;
    end else if (ctrl_wr && !locked_q) begin
      ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      locked_q <= 1'b1;
    end
  end

  // key sequence: any service write other than the arm key disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (svc_wr) armed_q <= (wdata_i == KEY_ARM);
  end

  assign reload_o = svc_wr && armed_q && (wdata_i == KEY_FIRE);
  assign ctrl_o   = ctrl_q;

  p_ctrl_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && ctrl_wr) |=> $stable(ctrl_q));

  p_fire_needs_arm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_wr && (wdata_i == KEY_FIRE) && !armed_q) |-> !reload_o);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned LOG2 = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sel_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [LOG2-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (clr_i)           div_q <= '0;
    else if (en_i && sel_i)   div_q <= div_q + 1'b1;
  end

  assign tick_o = en_i && (!sel_i || (&div_q));

  p_div_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(div_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] tmo_i,
  input  logic             tick_i,
  input  logic             route_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hard_o,
  output logic             mchk_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hard_q, mchk_q;
  logic             expire;

  assign expire = tick_i && !reload_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '1;
    else if (reload_i)                cnt_q <= tmo_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hard_q <= 1'b0;
      mchk_q <= 1'b0;
    end else begin
      hard_q <= expire && route_i;
      mchk_q <= expire && !route_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign hard_o = hard_q;
  assign mchk_o = mchk_q;

  p_reload_value_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cnt_q == $past(tmo_i)));

  p_pulse_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_q || mchk_q) |-> (cnt_q == '0));

  p_pulse_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_q || mchk_q) |=> !(hard_q || mchk_q));

  p_zero_sticks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == '0) && !reload_i) |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned PRESC_LOG2 = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_waddr_i,
  input  logic [31:0] bus_wdata_i,
  input  logic [1:0]  bus_raddr_i,
  output logic [31:0] bus_rdata_o,
  output logic        hard_rst_req_o,
  output logic        mchk_req_o
);
  ctrl_t            ctrl;
  logic             reload;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  wdog_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .waddr_i  (bus_waddr_i),
    .wdata_i  (bus_wdata_i),
    .ctrl_o   (ctrl),
    .reload_o (reload)
  );

  wdog_prescaler #(.LOG2(PRESC_LOG2)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.en),
    .sel_i  (ctrl.presc),
    .clr_i  (reload),
    .tick_o (tick)
  );

  wdog_counter u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload),
    .tmo_i    (ctrl.tmo),
    .tick_i   (tick),
    .route_i  (ctrl.route),
    .cnt_o    (cnt),
    .hard_o   (hard_rst_req_o),
    .mchk_o   (mchk_req_o)
  );

  always_comb begin
    unique case (bus_raddr_i)
      ADDR_CTRL: bus_rdata_o = BUS_W'(ctrl);
      ADDR_CNT:  bus_rdata_o = BUS_W'(cnt);
      default:   bus_rdata_o = '0;
    endcase
  end

  p_route_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hard_rst_req_o && mchk_req_o));

  p_disabled_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.en && !reload) |=> ($stable(cnt) && !hard_rst_req_o && !mchk_req_o));
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int unsigned PL = 4;
  localparam int unsigned PDIV = 1 << PL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  waddr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [1:0]  raddr = 2'd0;
  logic [31:0] rdata;
  logic        hard, mchk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  wdog_timer #(.PRESC_LOG2(PL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_waddr_i(waddr),
    .bus_wdata_i(wdata), .bus_raddr_i(raddr), .bus_rdata_o(rdata),
    .hard_rst_req_o(hard), .mchk_req_o(mchk)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input bit route, input bit presc, input bit en,
                                     input logic [15:0] tmo);
    return {13'd0, route, presc, en, tmo};
  endfunction

  // caller sits at a negedge; exactly one posedge sees the write
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = 32'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    raddr = a; #1; d = rdata;
  endtask

  task automatic service();
    wr(2'd1, 32'h0000_556C);
    wr(2'd1, 32'h0000_AA39);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0;
    @(negedge clk);
    rd(2'd0, d); chk("R1 ctrl in reset", d, 32'h0005_FFFF);
    rd(2'd2, d); chk("R1 count in reset", d, 32'h0000_FFFF);
    chk("R1 outputs in reset", {30'd0, hard, mchk}, 32'd0);
    rd(2'd1, d); chk("R2 service reads zero", d, 32'd0);
    rd(2'd3, d); chk("R2 unused address reads zero", d, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd2, d); chk("R3 one decrement after reset", d, 32'h0000_FFFE);
  endtask

  task automatic t_deferred();
    logic [31:0] d;
    do_reset();
    wr(2'd0, cw(1, 0, 1, 16'd20));
    rd(2'd2, d); chk("R7 count unchanged by new timeout", {31'd0, d > 32'hFF00}, 32'd1);
    service();
    rd(2'd2, d); chk("R7 count loaded on service", d, 32'd20);
    repeat (5) @(negedge clk);
    rd(2'd2, d); chk("R3 per-clock decrement", d, 32'd15);
  endtask

  task automatic t_expiry(input bit route);
    logic [31:0] d;
    do_reset();
    wr(2'd0, cw(route, 0, 1, 16'd10));
    service();
    repeat (9) @(negedge clk);
    rd(2'd2, d); chk("R5 count one before expiry", d, 32'd1);
    chk("R5 no request before expiry", {30'd0, hard, mchk}, 32'd0);
    @(negedge clk);
    rd(2'd2, d); chk("R5 count zero at expiry", d, 32'd0);
    chk("R6 routed request", {30'd0, hard, mchk}, route ? 32'd2 : 32'd1);
    @(negedge clk);
    chk("R5 request lasts one cycle", {30'd0, hard, mchk}, 32'd0);
    repeat (5) @(negedge clk);
    rd(2'd2, d); chk("R5 count stays zero", d, 32'd0);
    chk("R5 no repeat request", {30'd0, hard, mchk}, 32'd0);
    service();
    rd(2'd2, d); chk("R5 reload after expiry", d, 32'd10);
  endtask

  task automatic t_sequence();
    logic [31:0] d;
    do_reset();
    wr(2'd0, cw(1, 0, 1, 16'd50));
    service();
    repeat (5) @(negedge clk);
    wr(2'd1, 32'h0000_556C);
    wr(2'd1, 32'h0000_1234);
    wr(2'd1, 32'h0000_AA39);
    rd(2'd2, d); chk("R8 broken sequence no reload", d, 32'd42);
    wr(2'd1, 32'h0000_AA39);
    rd(2'd2, d); chk("R8 lone second key no reload", d, 32'd41);
    wr(2'd1, 32'h0000_556C);
    rd(2'd2, d); chk("R8 first key alone no reload", d, 32'd40);
    wr(2'd1, 32'h0000_AA39);
    rd(2'd2, d); chk("R8 full sequence reloads", d, 32'd50);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    do_reset();
    wr(2'd0, cw(1, 0, 0, 16'd30));
    service();
    rd(2'd2, d); chk("R9 reload while disabled", d, 32'd30);
    repeat (40) @(negedge clk);
    rd(2'd2, d); chk("R9 count held while disabled", d, 32'd30);
    chk("R9 no request while disabled", {30'd0, hard, mchk}, 32'd0);
    wr(2'd0, cw(1, 0, 1, 16'd30));
    rd(2'd0, d); chk("R10 enable cannot be set again", d, cw(1, 0, 0, 16'd30));
    repeat (5) @(negedge clk);
    rd(2'd2, d); chk("R10 still stopped after rewrite", d, 32'd30);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    wr(2'd0, cw(0, 0, 1, 16'd100));
    wr(2'd0, cw(1, 1, 0, 16'd7));
    rd(2'd0, d); chk("R10 second control write ignored", d, cw(0, 0, 1, 16'd100));
    service();
    rd(2'd2, d); chk("R10 first timeout kept", d, 32'd100);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    do_reset();
    wr(2'd0, cw(0, 1, 1, 16'd3));
    repeat (3) @(negedge clk);
    service();
    rd(2'd2, d); chk("R4 loaded", d, 32'd3);
    repeat (PDIV - 1) @(negedge clk);
    rd(2'd2, d); chk("R4 no decrement before period", d, 32'd3);
    @(negedge clk);
    rd(2'd2, d); chk("R4 decrement at period", d, 32'd2);
    repeat (2 * PDIV - 1) @(negedge clk);
    rd(2'd2, d); chk("R4 count one", d, 32'd1);
    chk("R4 no early request", {30'd0, hard, mchk}, 32'd0);
    @(negedge clk);
    chk("R6 prescaled interrupt request", {30'd0, hard, mchk}, 32'd1);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    bit seen = 1'b0;
    do_reset();
    wr(2'd0, cw(1, 0, 1, 16'd0));
    service();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (hard || mchk) seen = 1'b1;
    end
    rd(2'd2, d); chk("R11 zero timeout count", d, 32'd0);
    chk("R11 zero timeout no request", {31'd0, seen}, 32'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_deferred();
    t_expiry(1'b1);
    t_expiry(1'b0);
    t_sequence();
    t_disable();
    t_lock();
    t_prescale();
    t_zero();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule